// File: doc/BRIEF.md
# Masked Frame-Mapped Tile Configuration Memory

This block is the configuration store of a single programmable-fabric tile. A 32-bit frame data bus is shared by all frames of the tile. A one-hot vector of frame strobes, one line per frame, picks which frame captures the bus on a clock edge. Each frame has a fixed 32-bit usage mask. Only the positions whose mask bit is set own a flip-flop; the other positions are tied to zero and have no storage. The stored bits are then steered, through a fixed ordered placement list per frame, into a flat 538-bit tile configuration vector. That vector feeds the tile's logic elements, the LUT cascade control and the switch matrix.

The vector is laid out as follows. Eight logic-element fields of 18 bits each sit at tile bits 0 to 143. Each field holds a 16-bit truth table, an output-select bit and a carry-select bit. The two cascade-control bits are tile bits 144 and 145. The switch-matrix selects are tile bits 146 to 537. Frames 0 and 1 use hand-arranged masks so that the first two truth tables fill the frame high halves. The remaining 500 tile bits are packed in ascending order into frames 2 to 17. Frames 18 and 19 carry no storage at all.

Top module: `tile_cfg_mem`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and after it is released, every bit of `tile_cfg` is 0 until a frame is written.
- R2: Frame 0 has usage mask 0xFFFF1111. Frame data bits 31..16 drive tile bits 15..0 (bit 31 to tile 15). Data bits 12, 8, 4 and 0 drive tile bits 16, 17, 144 and 145 respectively.
- R3: Frame 1 has usage mask 0xFFFF1100. Frame data bits 31..16 drive tile bits 33..18 (bit 31 to tile 33). Data bits 12 and 8 drive tile bits 34 and 35.
- R4: For frames 2 to 17, frame data bit p drives tile bit s+36 when s<108 and tile bit s+38 otherwise, where s = 32*(frame-2)+p. In frame 17 only bits 19..0 are used. Frames 18 and 19 have no used bits, so writing them leaves `tile_cfg` unchanged.
- R5: Frame data bits at positions where the frame's usage mask is 0 have no effect on `tile_cfg`.
- R6: When exactly one strobe bit is set on a rising clock edge, that frame captures its masked data bits. All other frames keep their contents.
- R7: A strobe vector with two or more bits set writes nothing, and `tile_cfg` is unchanged.
- R8: An all-zero strobe vector leaves `tile_cfg` unchanged.
- R9: A write becomes visible on `tile_cfg` right after the rising clock edge that samples the strobe, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; frames capture on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all stored bits |
| frame_data | input | 32 | Frame data bus shared by all frames |
| frame_strobe | input | 20 | One strobe per frame; bit f selects frame f |
| tile_cfg | output | 538 | Flat tile configuration vector |

## Verification
Storage sits directly behind the output through a wiring-only placement. So a wrong stored bit, a wrongly placed bit or a missed hold shows up on `tile_cfg` in the cycle right after the edge that caused it. The bench compares the whole vector after each write against a model built from the mask and list rules. A misplaced bit therefore appears either as a missing bit in the target field or as a stray bit in a neighbouring field. Blocked writes (multiple strobes, empty frames, unused positions) are judged the same way, by checking the whole vector for no change one cycle after the attempt.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

   // frame geometry
   localparam int FRAME_W      = 32;
   localparam int NUM_FRAMES   = 20;
   // tile content geometry
   localparam int LE_COUNT     = 8;
   localparam int TT_W         = 16;
   localparam int LE_CFG_W     = TT_W + 2;
   localparam int CASCADE_W    = 2;
   localparam int SWITCH_W     = 392;

   localparam int CASC_LO      = LE_COUNT * LE_CFG_W;
   localparam int SWITCH_LO    = CASC_LO + CASCADE_W;
   localparam int TILE_W       = SWITCH_LO + SWITCH_W;

   // frames 0 and 1 are hand-arranged, the rest is packed in order
   localparam int HEAD_FRAMES  = 2;
   localparam int HEAD_BITS    = 2 * LE_CFG_W + CASCADE_W;
   localparam int PACKED_BITS  = TILE_W - HEAD_BITS;
   localparam int PACKED_FRAMES = (PACKED_BITS + FRAME_W - 1) / FRAME_W;

   typedef logic [FRAME_W-1:0]    frame_t;
   typedef logic [NUM_FRAMES-1:0] strobe_t;

   // usage mask of one frame
   function automatic frame_t frame_mask(input int f);
      int rem;
      if (f == 0)      return frame_t'(32'hFFFF_1111);
      else if (f == 1) return frame_t'(32'hFFFF_1100);
      rem = PACKED_BITS - (f - HEAD_FRAMES) * FRAME_W;
      if (rem <= 0)            return '0;
      else if (rem >= FRAME_W) return '1;
      else                     return (frame_t'(1) << rem) - frame_t'(1);
   endfunction

   // position in the packed stream of a tile bit outside the head frames
   function automatic int packed_index(input int t);
      return (t < CASC_LO) ? t - 2 * LE_CFG_W : t - HEAD_BITS;
   endfunction

   // frame position inside a head frame for a logic-element field offset
   function automatic int head_pos(input int o);
      if (o < TT_W)      return FRAME_W - TT_W + o;
      else if (o == TT_W) return 12;
      else               return 8;
   endfunction

   function automatic int src_frame(input int t);
      if (t < LE_CFG_W)                             return 0;
      else if (t < 2 * LE_CFG_W)                    return 1;
      else if (t == CASC_LO || t == CASC_LO + 1)    return 0;
      else return HEAD_FRAMES + packed_index(t) / FRAME_W;
   endfunction

   function automatic int src_pos(input int t);
      if (t < LE_CFG_W)            return head_pos(t);
      else if (t < 2 * LE_CFG_W)   return head_pos(t - LE_CFG_W);
      else if (t == CASC_LO)       return 4;
      else if (t == CASC_LO + 1)   return 0;
      else return packed_index(t) % FRAME_W;
   endfunction

   function automatic int used_total();
      int n;
      frame_t m;
      n = 0;
      for (int f = 0; f < NUM_FRAMES; f++) begin
         m = frame_mask(f);
         for (int p = 0; p < FRAME_W; p++) n += int'(m[p]);
      end
      return n;
   endfunction

   function automatic strobe_t empty_frames();
      strobe_t e;
      for (int f = 0; f < NUM_FRAMES; f++) e[f] = (frame_mask(f) == '0);
      return e;
   endfunction

endpackage

// File: rtl/tcm_strobe_guard.sv
module tcm_strobe_guard #(
   parameter int N = 20
) (
   input  logic [N-1:0] strobe,
   output logic [N-1:0] wr_en
);
   logic at_most_one;

   // clearing the lowest set bit leaves zero only for zero or one set bits
   assign at_most_one = ((strobe & (strobe - N'(1))) == '0);
   assign wr_en       = at_most_one ? strobe : '0;

   always_comb begin
      assert_single_write_R7: assert ($onehot0(wr_en));
   end
endmodule

// File: rtl/tcm_frame_store.sv
module tcm_frame_store #(
   parameter int               FRAME_W = 32,
   parameter logic [FRAME_W-1:0] MASK  = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [FRAME_W-1:0] d,
   output logic [FRAME_W-1:0] q
);
   for (genvar p = 0; p < FRAME_W; p++) begin : g_bit
      if (MASK[p]) begin : g_store
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  bit_q <= 1'b0;
            else if (we) bit_q <= d[p];
         end
         assign q[p] = bit_q;
      end else begin : g_void
         assign q[p] = 1'b0;
      end
   end

   assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == ($past(d) & MASK)));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/tcm_tile_map.sv
module tcm_tile_map
   import tcm_pkg::*;
(
   input  logic [NUM_FRAMES-1:0][FRAME_W-1:0] frames,
   output logic [TILE_W-1:0]                  tile_cfg
);
   for (genvar t = 0; t < TILE_W; t++) begin : g_tile
      localparam int SF = src_frame(t);
      localparam int SP = src_pos(t);
      assign tile_cfg[t] = frames[SF][SP];
   end

   for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_chk
      localparam frame_t FM = frame_mask(f);
      always_comb begin
         assert_unused_zero_R5: assert ((frames[f] & ~FM) == '0);
      end
   end
endmodule

// File: rtl/tile_cfg_mem.sv
module tile_cfg_mem
   import tcm_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [FRAME_W-1:0]    frame_data,
   input  logic [NUM_FRAMES-1:0] frame_strobe,
   output logic [TILE_W-1:0]     tile_cfg
);
   localparam strobe_t EMPTY = empty_frames();

   // elaboration-time consistency of the frame map
   if (FRAME_W != 32)                             $error("frame map assumes 32-bit frames");
   if (LE_CFG_W != TT_W + 2 || LE_COUNT < 2)      $error("logic element field layout mismatch");
   if (CASCADE_W != 2)                            $error("cascade field must be two bits");
   if (NUM_FRAMES < HEAD_FRAMES + PACKED_FRAMES)  $error("not enough frames for the tile");
   if (used_total() != TILE_W)                    $error("mask population differs from tile width");

   logic [NUM_FRAMES-1:0]              wr_en;
   logic [NUM_FRAMES-1:0][FRAME_W-1:0] frame_q;

   tcm_strobe_guard #(.N(NUM_FRAMES)) u_guard (
      .strobe (frame_strobe),
      .wr_en  (wr_en)
   );

   for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
      tcm_frame_store #(.FRAME_W(FRAME_W), .MASK(frame_mask(f))) u_store (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_en[f]),
         .d     (frame_data),
         .q     (frame_q[f])
      );
   end

   tcm_tile_map u_map (
      .frames   (frame_q),
      .tile_cfg (tile_cfg)
   );

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (tile_cfg == '0));

   assert_multi_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(frame_strobe) > 1) |=> $stable(tile_cfg));

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_strobe == '0) |=> $stable(tile_cfg));

   assert_empty_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((frame_strobe & EMPTY) != '0) |=> $stable(tile_cfg));
endmodule

// File: tb/test_tile_cfg_mem.sv
module test_tile_cfg_mem;
   localparam int CLK_PERIOD = 10;
   localparam int TW = 538;
   localparam int NF = 20;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [31:0]   frame_data;
   logic [NF-1:0] frame_strobe;
   logic [TW-1:0] tile_cfg;
   logic [TW-1:0] exp_cfg;
   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tile_cfg_mem i_tile_cfg_mem (
      .clk(clk), .rst_n(rst_n), .frame_data(frame_data),
      .frame_strobe(frame_strobe), .tile_cfg(tile_cfg)
   );

   typedef struct packed {
      logic [NF-1:0] strb;
      logic [31:0]   data;
   } vec_t;

   // R6 single writes, R4 packed/empty frames, R8 idle, R7 multi-strobe
   localparam vec_t VECS [12] = '{
      '{20'h00001, 32'hFFFF_FFFF},
      '{20'h00002, 32'hA5A5_A5A5},
      '{20'h00004, 32'h1234_5678},
      '{20'h00020, 32'h0000_F000},
      '{20'h20000, 32'hFFFF_FFFF},
      '{20'h40000, 32'hFFFF_FFFF},
      '{20'h00000, 32'hFFFF_FFFF},
      '{20'h00018, 32'hFFFF_FFFF},
      '{20'h00001, 32'h0000_0000},
      '{20'h10000, 32'hDEAD_BEEF},
      '{20'h80000, 32'hFFFF_FFFF},
      '{20'h00200, 32'hC3C3_C3C3}
   };

   function automatic logic [31:0] m_mask(input int f);
      if (f == 0) return 32'hFFFF_1111;
      if (f == 1) return 32'hFFFF_1100;
      if (f >= 2 && f <= 16) return 32'hFFFF_FFFF;
      if (f == 17) return 32'h000F_FFFF;
      return 32'h0;
   endfunction

   // tile bit for the k-th used position counted from the MSB
   function automatic int m_tile(input int f, input int k);
      int pos, s;
      if (f == 0) begin
         if (k < 16) return 15 - k;
         if (k == 16) return 16;
         if (k == 17) return 17;
         if (k == 18) return 144;
         return 145;
      end
      if (f == 1) begin
         if (k < 16) return 33 - k;
         if (k == 16) return 34;
         return 35;
      end
      pos = ((f == 17) ? 19 : 31) - k;
      s = 32 * (f - 2) + pos;
      return (s < 108) ? s + 36 : s + 38;
   endfunction

   task automatic model_write(input logic [NF-1:0] strb, input logic [31:0] d);
      logic [31:0] m;
      int k;
      if ($countones(strb) != 1) return;
      for (int f = 0; f < NF; f++) begin
         if (strb[f]) begin
            m = m_mask(f);
            k = 0;
            for (int p = 31; p >= 0; p--) begin
               if (m[p]) begin
                  exp_cfg[m_tile(f, k)] = d[p];
                  k++;
               end
            end
         end
      end
   endtask

   task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [NF-1:0] strb, input logic [31:0] d);
      @(negedge clk);
      frame_strobe = strb;
      frame_data   = d;
      @(negedge clk);
      frame_strobe = '0;
      model_write(strb, d);
   endtask

   function automatic logic [TW-1:0] bits(input int a, input int b, input int c);
      logic [TW-1:0] v;
      v = '0;
      if (a >= 0) v[a] = 1'b1;
      if (b >= 0) v[b] = 1'b1;
      if (c >= 0) v[c] = 1'b1;
      return v;
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL R9 watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [TW-1:0] hand;
      string tag;
      rst_n = 1'b0;
      frame_strobe = '0;
      frame_data = '0;
      exp_cfg = '0;
      repeat (3) @(negedge clk);
      check("R1 reset", tile_cfg, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", tile_cfg, '0);

      // vector table
      for (int i = 0; i < 12; i++) begin
         if (VECS[i].strb == '0) tag = "R8 idle";
         else if ($countones(VECS[i].strb) > 1) tag = "R7 multi";
         else if ((VECS[i].strb & 20'hC0000) != '0) tag = "R4 empty frame";
         else tag = "R6 write";
         do_write(VECS[i].strb, VECS[i].data);
         check(tag, tile_cfg, exp_cfg);
      end

      // mid-run reset
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 mid-run reset", tile_cfg, '0);
      @(negedge clk);
      rst_n = 1'b1;
      exp_cfg = '0;

      // directed placement checks with hand-computed vectors
      hand = '0;
      do_write(20'h00002, 32'h0000_00FF);
      check("R5 unused positions frame1", tile_cfg, hand);
      do_write(20'h00001, 32'h8000_1010);
      hand |= bits(15, 16, 144);
      check("R2 frame0 placement", tile_cfg, hand);
      do_write(20'h00002, 32'h8000_0100);
      hand |= bits(33, 35, -1);
      check("R3 frame1 placement", tile_cfg, hand);
      do_write(20'h00004, 32'h0000_0001);
      hand |= bits(36, -1, -1);
      check("R4 frame2 bit0", tile_cfg, hand);
      do_write(20'h00020, 32'h0000_1000);
      hand |= bits(146, -1, -1);
      check("R4 switch region start", tile_cfg, hand);
      do_write(20'h20000, 32'h0008_0000);
      hand |= bits(537, -1, -1);
      check("R4 last tile bit", tile_cfg, hand);
      do_write(20'h20000, 32'hFFF8_0000);
      check("R5 unused positions frame17", tile_cfg, hand);
      do_write(20'h00005, 32'h0000_0000);
      check("R7 multi-strobe ignored", tile_cfg, hand);
      check("R6 model agrees", tile_cfg, exp_cfg);

      // R9: not visible before the sampling edge, visible right after it
      @(negedge clk);
      frame_strobe = 20'h00001;
      frame_data = 32'h0001_0000;
      #(CLK_PERIOD/4);
      check("R9 before edge", tile_cfg, hand);
      @(posedge clk);
      #1;
      frame_strobe = '0;
      hand[15] = 1'b0;
      hand[16] = 1'b0;
      hand[144] = 1'b0;
      hand[0] = 1'b1;
      check("R9 after edge", tile_cfg, hand);

      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule